// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a set of wide event counters for a processor core. The pipeline drives a vector of one-cycle event pulses, one bit per counter slot. A counter advances when its pulse arrives and counting is allowed for it. Counting is allowed when the global run bit is set, the counter's own count-enable bit is set, and the current privilege level (supervisor or user) is enabled in the control register. A counter that steps past its top value returns to zero and latches its bit in an overflow status register. One shared interrupt line is raised while any latched overflow has its interrupt-enable bit set.

Software reaches the bank through a single-cycle register port. A space-select input picks either the counter space, where each counter appears as a low and a high 32-bit half, or the control space. Read data comes back registered one cycle after the request. The usual sampling scheme preloads a counter with the two's complement of the wanted period, so that the wrap and its interrupt arrive after exactly that many events. A wide value is read as two halves, and software re-reads the high half until it matches.

Top module: `pmc_bank`

## Requirements
- R1: Counter slots 1 to 8 and 10 to 27 carry counters; slots 0, 9 and 28 to 31 have none. In counter space, slot n's low 32 bits sit at address 2n and its upper CNT_W-32 bits at 2n+1, and the high half reads zero-extended. Empty slots read as zero, ignore writes and never set an overflow bit.
- R2: A counter adds one on a cycle where its event bit is 1 only when control bit 0 (run), its count-enable bit, and the privilege bit are all 1. The privilege bit is control bit 2 when priv_user_i is 0 and control bit 3 when priv_user_i is 1.
- R3: A counter at 2^CNT_W-1 that counts goes to 0 and sets its bit in the overflow status register.
- R4: irq_o is 1 exactly while some overflow bit and the matching interrupt-enable bit are both 1.
- R5: A write to the overflow status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A wrap in the same cycle still sets its bit.
- R6: Writing the control register with bits 31 and 30 both 1 clears every counter and every overflow bit at that clock edge. The two bits read back as 1 for one cycle and then return to 0, while the other written bits are kept.
- R7: A write to a counter half replaces only that half at the next edge. If that counter has an event in the same cycle, the event is dropped and sets no overflow bit.
- R8: A read returns its data on reg_rdata_o one cycle after the request, and the data holds until the next read. Each half shows the live value at its own read, so a carry between two half reads is visible.
- R9: Control space: address 0 is control, 4 is count enable, 5 is interrupt enable, 6 is overflow status. All other control addresses read zero and ignore writes.
- R10: After reset, all counters, control, enable and status registers are zero, and irq_o is 0.
- R11: A counter preloaded with (2^CNT_W - P) and enabled sets its overflow bit on exactly the P-th counted event, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | One-cycle event pulses, one bit per counter slot |
| priv_user_i | input | 1 | 1 when the core runs in user mode, 0 in supervisor mode |
| reg_en_i | input | 1 | Register access valid this cycle |
| reg_we_i | input | 1 | 1 for write, 0 for read |
| reg_ctl_i | input | 1 | 1 selects control space, 0 selects counter space |
| reg_addr_i | input | 8 | Register address within the selected space |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
The bench sweeps every combination of run bit, both privilege bits, count enable and privilege level on three slots. A design that decodes the privilege bits the wrong way round or ignores one of the gates counts when it should stay still. Preloads of 2^CNT_W-P for several P catch a wrap one event early or late. A same-cycle event and half write, and a same-cycle wrap and status clear, expose wrong priorities. A read across a low-half carry shows whether the high half is latched instead of live. The empty slots 0, 9 and 28 to 31 are written and read back to catch a decoder that lets them hold data. The bank-clear command is read back twice to check that its bits self-clear.

// File: rtl/pmc_pkg.sv
// Shared constants for the performance counter bank.
// Assumes a 32-slot index space with 32-bit register data.
package pmc_pkg;
    localparam int N_SLOT  = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    // Control-space addresses
    localparam logic [ADDR_W-1:0] CA_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] CA_CNTEN = 8'h04;
    localparam logic [ADDR_W-1:0] CA_INTEN = 8'h05;
    localparam logic [ADDR_W-1:0] CA_OVF   = 8'h06;

    // Control register bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_SUPV = 2;
    localparam int CB_USER = 3;
    localparam int CB_CLRA = 30;
    localparam int CB_CLRB = 31;

    // Default population: slots 1..8 and 10..27
    localparam logic [N_SLOT-1:0] POP_DEFAULT = 32'h0FFF_FDFE;
endpackage

// File: rtl/pmc_counter.sv
// One wide event counter with split-half load.
// Assumes CNT_W lies between 33 and 64. Clear beats load, load beats increment.
module pmc_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] value_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Wrap pulse: a counted event while the counter sits at its top value
    always_comb begin
        wrap_o = inc_i && !wr_lo_i && !wr_hi_i && !clr_i && (cnt_q == CNT_MAX);
    end

    // Counter state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) cnt_q[31:0]      <= ld_val_i[31:0];
            if (wr_hi_i) cnt_q[CNT_W-1:32] <= ld_val_i[CNT_W-1:32];
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value_o = cnt_q;
endmodule

// File: rtl/pmc_ctrl_regs.sv
// Control, enable and overflow-status registers for the counter bank.
// Produces per-slot count gates, the bank clear pulse and the interrupt.
module pmc_ctrl_regs
    import pmc_pkg::*;
#(
    parameter logic [N_SLOT-1:0] POP_MASK = POP_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en_i,
    input  logic              reg_we_i,
    input  logic              reg_ctl_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              priv_user_i,
    input  logic [N_SLOT-1:0] wrap_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [N_SLOT-1:0] cnten_o,
    output logic [N_SLOT-1:0] inten_o,
    output logic [N_SLOT-1:0] ovf_o,
    output logic              clr_o,
    output logic [N_SLOT-1:0] cnt_ok_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] ctrl_q;
    logic [N_SLOT-1:0] cnten_q, inten_q, ovf_q;
    logic              ctl_wr, mode_ok;

    // Decode control-space writes and the bank-clear command
    always_comb begin
        ctl_wr = reg_en_i && reg_we_i && reg_ctl_i;
        clr_o  = ctl_wr && (reg_addr_i == CA_CTRL) &&
                 reg_wdata_i[CB_CLRB] && reg_wdata_i[CB_CLRA];
    end

    // Control register with self-clearing clear bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctl_wr && reg_addr_i == CA_CTRL) begin
            ctrl_q <= reg_wdata_i;
        end else begin
            ctrl_q[CB_CLRB] <= 1'b0;
            ctrl_q[CB_CLRA] <= 1'b0;
        end
    end

    // Count-enable and interrupt-enable masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnten_q <= '0;
            inten_q <= '0;
        end else begin
            if (ctl_wr && reg_addr_i == CA_CNTEN) cnten_q <= reg_wdata_i;
            if (ctl_wr && reg_addr_i == CA_INTEN) inten_q <= reg_wdata_i;
        end
    end

    // Overflow status: write-zero-to-clear, wrap sets, bank clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else if (clr_o) begin
            ovf_q <= '0;
        end else if (ctl_wr && reg_addr_i == CA_OVF) begin
            ovf_q <= ((ovf_q & reg_wdata_i) | wrap_i) & POP_MASK;
        end else begin
            ovf_q <= (ovf_q | wrap_i) & POP_MASK;
        end
    end

    // Per-slot count gate from run bit, privilege filter and enable mask
    always_comb begin
        mode_ok  = priv_user_i ? ctrl_q[CB_USER] : ctrl_q[CB_SUPV];
        cnt_ok_o = {N_SLOT{ctrl_q[CB_RUN] && mode_ok}} & cnten_q & POP_MASK;
        irq_o    = |(ovf_q & inten_q);
    end

    assign ctrl_o  = ctrl_q;
    assign cnten_o = cnten_q;
    assign inten_o = inten_q;
    assign ovf_o   = ovf_q;
endmodule

// File: rtl/pmc_rdmux.sv
// Registered read path for both register spaces.
// Assumes empty slots present a zero value; read data holds between reads.
module pmc_rdmux
    import pmc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_i,
    input  logic                          ctl_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             ctrl_i,
    input  logic [N_SLOT-1:0]             cnten_i,
    input  logic [N_SLOT-1:0]             inten_i,
    input  logic [N_SLOT-1:0]             ovf_i,
    input  logic [N_SLOT-1:0][CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0]             rdata_o
);
    logic [CNT_W-1:0]  sel_cnt;
    logic [63:0]       sel_wide;
    logic [DATA_W-1:0] rd_next, rdata_q;

    // Pick the addressed counter (zero when out of range)
    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (addr_i[ADDR_W-1:1] == 7'(i)) sel_cnt = cnt_i[i];
        end
        sel_wide = 64'(sel_cnt);
    end

    // Select read data from the chosen space
    always_comb begin
        rd_next = '0;
        if (ctl_i) begin
            case (addr_i)
                CA_CTRL:  rd_next = ctrl_i;
                CA_CNTEN: rd_next = cnten_i;
                CA_INTEN: rd_next = inten_i;
                CA_OVF:   rd_next = ovf_i;
                default:  rd_next = '0;
            endcase
        end else begin
            rd_next = addr_i[0] ? sel_wide[63:32] : sel_wide[31:0];
        end
    end

    // Capture on a read request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_next;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/pmc_bank.sv
// Performance counter bank top: instantiates a counter on each populated
// slot, the control registers and the registered read path.
// Assumes a single-cycle register port and one-cycle event pulses.
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int                CNT_W    = 48,
    parameter logic [N_SLOT-1:0] POP_MASK = POP_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] evt_i,
    input  logic              priv_user_i,
    input  logic              reg_en_i,
    input  logic              reg_we_i,
    input  logic              reg_ctl_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [N_SLOT-1:0][CNT_W-1:0] cnt_val;
    logic [N_SLOT-1:0]            wrap_vec, cnt_ok;
    logic [DATA_W-1:0]            ctrl_q;
    logic [N_SLOT-1:0]            cnten_q, inten_q, ovf_q;
    logic                         bank_clr, gen_wr, rd_req;
    logic [CNT_W-1:0]             ld_val;

    // Decode counter-space writes and reads
    always_comb begin
        gen_wr = reg_en_i && reg_we_i && !reg_ctl_i;
        rd_req = reg_en_i && !reg_we_i;
        ld_val = {reg_wdata_i[HI_W-1:0], reg_wdata_i};
    end

    pmc_ctrl_regs #(.POP_MASK(POP_MASK)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_en_i   (reg_en_i),
        .reg_we_i   (reg_we_i),
        .reg_ctl_i  (reg_ctl_i),
        .reg_addr_i (reg_addr_i),
        .reg_wdata_i(reg_wdata_i),
        .priv_user_i(priv_user_i),
        .wrap_i     (wrap_vec),
        .ctrl_o     (ctrl_q),
        .cnten_o    (cnten_q),
        .inten_o    (inten_q),
        .ovf_o      (ovf_q),
        .clr_o      (bank_clr),
        .cnt_ok_o   (cnt_ok),
        .irq_o      (irq_o)
    );

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        if (POP_MASK[g]) begin : g_cnt
            logic wr_lo, wr_hi;
            // Half-write strobes for this slot
            always_comb begin
                wr_lo = gen_wr && (reg_addr_i[ADDR_W-1:1] == 7'(g)) && !reg_addr_i[0];
                wr_hi = gen_wr && (reg_addr_i[ADDR_W-1:1] == 7'(g)) &&  reg_addr_i[0];
            end
            pmc_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (bank_clr),
                .wr_lo_i (wr_lo),
                .wr_hi_i (wr_hi),
                .ld_val_i(ld_val),
                .inc_i   (evt_i[g] && cnt_ok[g]),
                .value_o (cnt_val[g]),
                .wrap_o  (wrap_vec[g])
            );
        end else begin : g_empty
            assign cnt_val[g]  = '0;
            assign wrap_vec[g] = 1'b0;
        end
    end

    pmc_rdmux #(.CNT_W(CNT_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_req),
        .ctl_i  (reg_ctl_i),
        .addr_i (reg_addr_i),
        .ctrl_i (ctrl_q),
        .cnten_i(cnten_q),
        .inten_i(inten_q),
        .ovf_i  (ovf_q),
        .cnt_i  (cnt_val),
        .rdata_o(reg_rdata_o)
    );
endmodule

// File: rtl/pmc_bank_chk.sv
// Temporal checks for the counter bank, bound to pmc_bank.
module pmc_bank_chk
    import pmc_pkg::*;
#(
    parameter int                CNT_W    = 48,
    parameter logic [N_SLOT-1:0] POP_MASK = POP_DEFAULT
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_en_i,
    input logic                         reg_we_i,
    input logic                         reg_ctl_i,
    input logic [ADDR_W-1:0]            reg_addr_i,
    input logic [DATA_W-1:0]            reg_wdata_i,
    input logic [DATA_W-1:0]            reg_rdata_o,
    input logic                         irq_o,
    input logic [DATA_W-1:0]            ctrl_q,
    input logic [N_SLOT-1:0]            ovf_q,
    input logic [N_SLOT-1:0][CNT_W-1:0] cnt_val
);
    logic clr_cmd;
    assign clr_cmd = reg_en_i && reg_we_i && reg_ctl_i && (reg_addr_i == CA_CTRL) &&
                     reg_wdata_i[CB_CLRB] && reg_wdata_i[CB_CLRA];

    // R8: read data holds when no read is requested
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en_i && !reg_we_i) |=> $stable(reg_rdata_o));

    // R6: bank clear empties overflow status and drops the interrupt
    a_r6_clear_status: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (ovf_q == '0) && !irq_o);

    // R6: clear bits return to zero one cycle later
    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_CLRB] && !clr_cmd) |=> !ctrl_q[CB_CLRB] && !ctrl_q[CB_CLRA]);

    // R1: empty slots never report overflow
    a_r1_empty_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q & ~POP_MASK) == '0);

    for (genvar g = 0; g < N_SLOT; g++) begin : g_chk
        if (POP_MASK[g]) begin : g_pop
            // R7: low-half write lands on the next edge
            a_r7_low_write: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_en_i && reg_we_i && !reg_ctl_i &&
                 reg_addr_i == 8'(2 * g))
                |=> cnt_val[g][31:0] == $past(reg_wdata_i));
            // R3: a newly set overflow bit coincides with a counter at zero
            a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ovf_q[g]) |-> cnt_val[g] == '0);
        end
    end
endmodule

bind pmc_bank pmc_bank_chk #(.CNT_W(CNT_W), .POP_MASK(POP_MASK)) u_pmc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en_i   (reg_en_i),
    .reg_we_i   (reg_we_i),
    .reg_ctl_i  (reg_ctl_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o),
    .ctrl_q     (ctrl_q),
    .ovf_q      (ovf_q),
    .cnt_val    (cnt_val)
);

// File: tb/tb_pmc_bank.sv
module tb_pmc_bank;
    localparam logic [31:0] POP = 32'h0FFF_FDFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        priv_user_i = 1'b0;
    logic        reg_en_i = 1'b0, reg_we_i = 1'b0, reg_ctl_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pmc_bank dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_user_i(priv_user_i),
        .reg_en_i(reg_en_i), .reg_we_i(reg_we_i), .reg_ctl_i(reg_ctl_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic ctl, input logic [7:0] a, input logic [31:0] d);
        reg_en_i = 1'b1; reg_we_i = 1'b1; reg_ctl_i = ctl; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_en_i = 1'b0; reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic ctl, input logic [7:0] a, output logic [31:0] v);
        reg_en_i = 1'b1; reg_we_i = 1'b0; reg_ctl_i = ctl; reg_addr_i = a;
        @(negedge clk);
        reg_en_i = 1'b0;
        v = reg_rdata_o;
    endtask

    task automatic pulse(input logic [31:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int slots [3];
        int pers  [3];
        slots = '{1, 10, 27};
        pers  = '{1, 2, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd(1'b1, 8'h00, v); chk("R10 ctrl", 64'(v), 64'h0);
        rd(1'b1, 8'h06, v); chk("R10 ovf", 64'(v), 64'h0);
        rd(1'b0, 8'h02, v); chk("R10 counter", 64'(v), 64'h0);
        chk("R10 irq", 64'(irq_o), 64'h0);

        // R1: write and read back both halves of every slot
        for (int i = 0; i < 32; i++) begin
            wr(1'b0, 8'(2 * i), 32'hA500_0000 | 32'(i));
            wr(1'b0, 8'(2 * i + 1), 32'h12C3_0000 | 32'(i));
        end
        for (int i = 0; i < 32; i++) begin
            rd(1'b0, 8'(2 * i), v);
            chk("R1 low half", 64'(v), POP[i] ? 64'(32'hA500_0000 | 32'(i)) : 64'h0);
            rd(1'b0, 8'(2 * i + 1), v);
            chk("R1 high half", 64'(v), POP[i] ? 64'(32'h0000_0000 | 32'(i)) : 64'h0);
        end

        // R9: unused control addresses read zero
        for (int a = 1; a < 16; a++) begin
            if (a == 4 || a == 5 || a == 6) continue;
            wr(1'b1, 8'(a), 32'hFFFF_FFFF);
            rd(1'b1, 8'(a), v); chk("R9 unused ctl addr", 64'(v), 64'h0);
        end

        // R6: bank clear, bits self-clear, counters zero
        wr(1'b1, 8'h00, 32'hC000_0002);
        rd(1'b1, 8'h00, v); chk("R6 clear bits visible", 64'(v), 64'hC000_0002);
        rd(1'b1, 8'h00, v); chk("R6 clear bits dropped", 64'(v), 64'h0000_0002);
        for (int i = 0; i < 32; i++) begin
            rd(1'b0, 8'(2 * i), v); chk("R6 counter cleared", 64'(v), 64'h0);
        end

        // R2: sweep gate combinations on three slots
        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 3; k++) begin
                int s;
                logic run, sv, us, ce, pu, go;
                s = slots[k];
                run = c[0]; sv = c[1]; us = c[2]; ce = c[3]; pu = c[4];
                go = run && ce && (pu ? us : sv);
                wr(1'b1, 8'h00, {28'b0, us, sv, 1'b0, run});
                wr(1'b1, 8'h04, 32'(ce) << s);
                priv_user_i = pu;
                wr(1'b0, 8'(2 * s), 32'h0);
                wr(1'b0, 8'(2 * s + 1), 32'h0);
                repeat (3) pulse(32'hFFFF_FFFF);
                rd(1'b0, 8'(2 * s), v);
                chk("R2 gated count", 64'(v), go ? 64'd3 : 64'd0);
            end
        end
        priv_user_i = 1'b0;

        // R3 R4 R5 R11: preload -P and count to the wrap
        for (int k = 0; k < 3; k++) begin
            int s, p;
            s = (k == 0) ? 5 : (k == 1) ? 27 : 10;
            p = pers[k];
            wr(1'b1, 8'h00, 32'hC000_0000);
            wr(1'b1, 8'h00, 32'h0000_0005);
            wr(1'b1, 8'h04, 32'h1 << s);
            wr(1'b1, 8'h05, 32'h0);
            wr(1'b0, 8'(2 * s), 32'h0 - 32'(p));
            wr(1'b0, 8'(2 * s + 1), 32'hFFFF_FFFF);
            for (int j = 0; j < p - 1; j++) pulse(32'h1 << s);
            rd(1'b1, 8'h06, v); chk("R11 no early overflow", 64'(v), 64'h0);
            pulse(32'h1 << s);
            rd(1'b1, 8'h06, v); chk("R11 overflow on P-th event", 64'(v), 64'(32'h1 << s));
            rd(1'b0, 8'(2 * s), v); chk("R3 low wraps to zero", 64'(v), 64'h0);
            rd(1'b0, 8'(2 * s + 1), v); chk("R3 high wraps to zero", 64'(v), 64'h0);
            chk("R4 irq masked", 64'(irq_o), 64'h0);
            wr(1'b1, 8'h05, 32'h1 << s);
            chk("R4 irq raised", 64'(irq_o), 64'h1);
            wr(1'b1, 8'h06, 32'hFFFF_FFFF);
            rd(1'b1, 8'h06, v); chk("R5 ones keep", 64'(v), 64'(32'h1 << s));
            wr(1'b1, 8'h06, ~(32'h1 << s));
            rd(1'b1, 8'h06, v); chk("R5 zero clears", 64'(v), 64'h0);
            chk("R4 irq dropped", 64'(irq_o), 64'h0);
        end

        // R5: wrap and clear-write in the same cycle
        wr(1'b1, 8'h04, 32'h0000_000E);
        wr(1'b0, 8'h02, 32'hFFFF_FFFF);
        wr(1'b0, 8'h03, 32'hFFFF_FFFF);
        evt_i = 32'h2;
        reg_en_i = 1'b1; reg_we_i = 1'b1; reg_ctl_i = 1'b1; reg_addr_i = 8'h06; reg_wdata_i = 32'h0;
        @(negedge clk);
        evt_i = '0; reg_en_i = 1'b0; reg_we_i = 1'b0;
        rd(1'b1, 8'h06, v); chk("R5 wrap beats clear", 64'(v), 64'h2);

        // R7: write beats a same-cycle event
        wr(1'b0, 8'h04, 32'h5);
        evt_i = 32'h4;
        reg_en_i = 1'b1; reg_we_i = 1'b1; reg_ctl_i = 1'b0; reg_addr_i = 8'h04; reg_wdata_i = 32'd100;
        @(negedge clk);
        evt_i = '0; reg_en_i = 1'b0; reg_we_i = 1'b0;
        rd(1'b0, 8'h04, v); chk("R7 write wins low", 64'(v), 64'd100);
        wr(1'b0, 8'h06, 32'hFFFF_FFFF);
        wr(1'b0, 8'h07, 32'hFFFF_FFFF);
        evt_i = 32'h8;
        reg_en_i = 1'b1; reg_we_i = 1'b1; reg_ctl_i = 1'b0; reg_addr_i = 8'h07; reg_wdata_i = 32'h0;
        @(negedge clk);
        evt_i = '0; reg_en_i = 1'b0; reg_we_i = 1'b0;
        rd(1'b0, 8'h06, v); chk("R7 low untouched", 64'(v), 64'hFFFF_FFFF);
        rd(1'b0, 8'h07, v); chk("R7 high replaced", 64'(v), 64'h0);
        rd(1'b1, 8'h06, v); chk("R7 dropped event no overflow", 64'(v), 64'h2);

        // R8: carry between half reads is visible, and data holds
        wr(1'b1, 8'h04, 32'h10);
        wr(1'b0, 8'h08, 32'hFFFF_FFFF);
        wr(1'b0, 8'h09, 32'h0000_0012);
        rd(1'b0, 8'h09, v); chk("R8 high before carry", 64'(v), 64'h12);
        pulse(32'h10);
        rd(1'b0, 8'h08, v); chk("R8 low after carry", 64'(v), 64'h0);
        rd(1'b0, 8'h09, v); chk("R8 high after carry", 64'(v), 64'h13);
        pulse(32'h10);
        pulse(32'h10);
        chk("R8 read data held", 64'(reg_rdata_o), 64'h13);

        // R6: clear command empties status and counters
        wr(1'b1, 8'h05, 32'h2);
        chk("R6 irq before clear", 64'(irq_o), 64'h1);
        wr(1'b1, 8'h00, 32'hC000_0000);
        chk("R6 irq after clear", 64'(irq_o), 64'h0);
        rd(1'b1, 8'h06, v); chk("R6 status cleared", 64'(v), 64'h0);
        rd(1'b0, 8'h08, v); chk("R6 counter cleared low", 64'(v), 64'h0);
        rd(1'b0, 8'h04, v); chk("R6 counter cleared slot2", 64'(v), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule